// File: doc/BRIEF.md
# Multi-Compare Interval Timer

This block is one 16-bit timer channel that advances on a slow tick-enable input. A programmable prescaler divides the ticks, and the counter then steps up or down by one on each divided tick. A separate reload register keeps the last value that software wrote to the counter. A 3-bit completion mode selects one of three behaviours: the counter stops when it reaches zero, it reloads when it hits one of six compare values, or it runs freely and wraps.

Each of the six compare values has its own sticky bit in a 6-bit status register. A bit is set whenever the live counter equals its compare value. Software clears a bit by writing a one to it, and a 6-bit mask selects which status bits raise the interrupt output. All configuration goes through a simple single-cycle register write port and a combinational read port.

Top module: `cmp_interval_timer`

## Requirements
- R1: While reset is held, the counter, divider, control, compares, status and mask registers all read zero and `irq` is low.
- R2: With divider value d, the counter advances once per d+1 clock cycles that have `tick_en` high. Cycles with `tick_en` low do not advance the prescaler.
- R3: Control bit 4 set to 1 freezes the counter and also holds the prescaler position.
- R4: Control bit 3 selects the direction (1 up, 0 down). Stepping wraps modulo 2^16.
- R5: Control bits 2:0 = 0: the counter steps until it reads zero, then stays at zero.
- R6: Control bits 2:0 = N (1..6): a step taken while the counter equals compare N loads the reload value instead of stepping.
- R7: Control bits 2:0 = 7: the counter steps forever and never reloads, even when it passes a compare value.
- R8: A write to the counter address loads both the counter and the reload register and restarts the prescaler from zero.
- R9: While the counter equals compare k (k = 1..6), status bit k-1 is set at the next clock edge.
- R10: Writing the status address clears each bit that is written as 1. Bits written as 0 are unchanged. A match in the same cycle keeps its bit set.
- R11: `irq` is high exactly when some status bit is set whose mask bit is also set.
- R12: Register addresses are: 0 counter, 1 divider, 2 control (5 bits), 3..8 compares 1..6, 9 status, 10 mask. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Slow tick enable, one clock cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that `wr_en` is a clean one-cycle strobe and that `tick_en` is never unknown once reset is released. They do not assume that a divider write keeps the prescaler position below the new divider. The stimulus changes inputs only at falling edges. It writes one register per strobe and raises `tick_en` only in bursts of a known length, so the number of counter steps follows directly from the divider. The stimulus moves the counter off every compare value before it clears status, so that sticky bits stay predictable.

// File: rtl/cit_pkg.sv
// Package: shared control-word layout and mode codes for the interval timer.
// Assumes a 3-bit mode field; code 0 = stop at zero, all-ones = free run.
package cit_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_STOP = '0;
    localparam logic [MODE_W-1:0] MODE_FREE = '1;

    typedef struct packed {
        logic              frz;   // bit 4
        logic              up;    // bit 3
        logic [MODE_W-1:0] mode;  // bits 2:0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cit_prescaler.sv
// Module: tick prescaler. Emits a one-cycle step after every div+1 enabled ticks.
// Assumes restart has priority; freeze holds the current position.
module cit_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             freeze,
    input  logic             restart,
    input  logic [CNT_W-1:0] divider,
    output logic             step
);
    logic [CNT_W-1:0] pos;
    logic             adv;

    // Purpose: decide whether this cycle consumes a tick and ends a period.
    always_comb begin
        adv  = tick_en && !freeze && !restart;
        step = adv && (pos >= divider);
    end

    // Purpose: track the tick position inside the current count period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pos <= '0;
        end else if (adv) begin
            pos <= (pos >= divider) ? '0 : pos + 1'b1;
        end
    end

    // R8
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pos == '0));
    // R3
    frozen_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !restart) |=> $stable(pos));
    // R2
    idle_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !restart) |=> $stable(pos));
endmodule

// File: rtl/cit_count_core.sv
// Module: 16-bit counter with reload register, direction and completion modes.
// Assumes NUM_CMP <= 2**MODE_W - 2 so that the mode codes do not overlap.
module cit_count_core
    import cit_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          step,
    input  logic                          load,
    input  logic [CNT_W-1:0]              load_val,
    input  ctrl_t                         ctrl,
    input  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0]              count,
    output logic [NUM_CMP-1:0]            match
);
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] stepped;
    logic [CNT_W-1:0] nxt;
    logic             sel_hit;
    logic             cmp_mode;

    // Purpose: one equality comparator per compare register.
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
        assign match[k] = (count == cmp_val[k]);
    end

    // Purpose: pick the completion compare and form the next counter value.
    always_comb begin
        sel_hit  = 1'b0;
        cmp_mode = 1'b0;
        for (int k = 0; k < NUM_CMP; k++) begin
            if (ctrl.mode == MODE_W'(k + 1)) begin
                cmp_mode = 1'b1;
                sel_hit  = match[k];
            end
        end
        stepped = ctrl.up ? count + 1'b1 : count - 1'b1;
        if (ctrl.mode == MODE_STOP) begin
            nxt = (count == '0) ? count : stepped;
        end else if (cmp_mode && sel_hit) begin
            nxt = reload;
        end else begin
            nxt = stepped;
        end
    end

    // Purpose: counter and reload storage; a software load beats a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            reload <= '0;
        end else if (load) begin
            count  <= load_val;
            reload <= load_val;
        end else if (step) begin
            count  <= nxt;
        end
    end

    // R5
    stop_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && ctrl.mode == MODE_STOP && count == '0) |=> (count == '0));
    // R6
    reload_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && cmp_mode && sel_hit) |=> (count == $past(reload)));
    // R2
    hold_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(count));
    // R8
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val) && reload == $past(load_val)));
endmodule

// File: rtl/cit_irq_status.sv
// Module: sticky per-compare status bits with write-one-to-clear and mask.
// Assumes match and clear can coincide; the match is kept.
module cit_irq_status #(
    parameter int NUM_CMP = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] match,
    input  logic               clr_we,
    input  logic [NUM_CMP-1:0] clr_bits,
    input  logic [NUM_CMP-1:0] mask,
    output logic [NUM_CMP-1:0] sts,
    output logic               irq
);
    // Purpose: per-bit set on match, clear on a written one, match wins.
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts[k] <= 1'b0;
            end else if (match[k]) begin
                sts[k] <= 1'b1;
            end else if (clr_we && clr_bits[k]) begin
                sts[k] <= 1'b0;
            end
        end

        // R9
        match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            match[k] |=> sts[k]);
        // R10
        w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_bits[k] && !match[k]) |=> !sts[k]);
        // R10
        w0_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sts[k] && !(clr_we && clr_bits[k])) |=> sts[k]);
    end

    // Purpose: combine enabled status bits into one request.
    assign irq = |(sts & mask);
endmodule

// File: rtl/cmp_interval_timer.sv
// Module: top of the interval timer channel; register file, read mux, wiring.
// Assumes single-cycle writes; reads are combinational from rd_addr.
module cmp_interval_timer
    import cit_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 6,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    localparam int A_CNT  = 0;
    localparam int A_DIV  = 1;
    localparam int A_CTRL = 2;
    localparam int A_CMP0 = 3;
    localparam int A_STS  = A_CMP0 + NUM_CMP;
    localparam int A_MASK = A_STS + 1;

    logic [CNT_W-1:0]              divider;
    ctrl_t                         ctrl;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val;
    logic [NUM_CMP-1:0]            mask;
    logic [NUM_CMP-1:0]            sts;
    logic [NUM_CMP-1:0]            match;
    logic [CNT_W-1:0]              count;
    logic                          step;
    logic                          wr_cnt;
    logic                          wr_sts;

    assign wr_cnt = wr_en && (wr_addr == ADDR_W'(A_CNT));
    assign wr_sts = wr_en && (wr_addr == ADDR_W'(A_STS));

    // Purpose: configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divider <= '0;
            ctrl    <= '0;
            mask    <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_DIV))  divider <= wr_data;
            if (wr_addr == ADDR_W'(A_CTRL)) ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_addr == ADDR_W'(A_MASK)) mask    <= wr_data[NUM_CMP-1:0];
        end
    end

    // Purpose: one compare register per generate slot.
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmpreg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_val[k] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(A_CMP0 + k)) begin
                cmp_val[k] <= wr_data;
            end
        end
    end

    cit_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .freeze  (ctrl.frz),
        .restart (wr_cnt),
        .divider (divider),
        .step    (step)
    );

    cit_count_core #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (wr_cnt),
        .load_val (wr_data),
        .ctrl     (ctrl),
        .cmp_val  (cmp_val),
        .count    (count),
        .match    (match)
    );

    cit_irq_status #(.NUM_CMP(NUM_CMP)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .clr_we   (wr_sts),
        .clr_bits (wr_data[NUM_CMP-1:0]),
        .mask     (mask),
        .sts      (sts),
        .irq      (irq)
    );

    // Purpose: combinational read multiplexer over the register map.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_CNT))  rd_data = count;
        if (rd_addr == ADDR_W'(A_DIV))  rd_data = divider;
        if (rd_addr == ADDR_W'(A_CTRL)) rd_data = CNT_W'(ctrl);
        if (rd_addr == ADDR_W'(A_STS))  rd_data = CNT_W'(sts);
        if (rd_addr == ADDR_W'(A_MASK)) rd_data = CNT_W'(mask);
        for (int k = 0; k < NUM_CMP; k++) begin
            if (rd_addr == ADDR_W'(A_CMP0 + k)) rd_data = cmp_val[k];
        end
    end

    // R3
    freeze_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.frz && !wr_cnt) |=> $stable(count));
    // R11
    no_mask_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: tb/cmp_interval_timer_tb.sv
module cmp_interval_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    cmp_interval_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    // {divider, control, initial count, ticks, expected count}
    localparam int NV = 11;
    localparam logic [79:0] VEC [NV] = '{
        {16'd0, 16'h0F, 16'd10,    16'd7,  16'd17},    // R4 up
        {16'd9, 16'h07, 16'd50,    16'd35, 16'd47},    // R2 div 9
        {16'd0, 16'h00, 16'd3,     16'd10, 16'd0},     // R5 down stop
        {16'd1, 16'h08, 16'hFFFE,  16'd10, 16'd0},     // R5 up wrap stop
        {16'd0, 16'h09, 16'd2,     16'd6,  16'd4},     // R6 mode 1
        {16'd0, 16'h02, 16'd103,   16'd5,  16'd102},   // R6 mode 2 down
        {16'd0, 16'h1F, 16'd20,    16'd8,  16'd20},    // R3 frozen
        {16'd2, 16'h0F, 16'd0,     16'd8,  16'd2},     // R2 div 2
        {16'd0, 16'h0F, 16'hFFFF,  16'd2,  16'd1},     // R4 wrap
        {16'd0, 16'h0E, 16'd398,   16'd4,  16'd399},   // R6 mode 6
        {16'd0, 16'h0F, 16'd3,     16'd4,  16'd7}      // R7 passes cmp1
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        // R1 reset state
        repeat (3) @(negedge clk);
        for (int a = 0; a < 11; a++) begin
            rd(4'(a), v);
            chk("R1 reset register", v, 16'h0);
        end
        chk("R1 reset irq", 16'(irq), 16'h0);
        rst_n = 1'b1;

        wr(4'd3, 16'd5);   wr(4'd4, 16'd100); wr(4'd5, 16'hFFF0);
        wr(4'd6, 16'd200); wr(4'd7, 16'd300); wr(4'd8, 16'd400);
        for (int k = 0; k < 6; k++) begin
            rd(4'(3 + k), v);
            chk("R12 compare readback", v, (k == 0) ? 16'd5 : (k == 1) ? 16'd100 :
                (k == 2) ? 16'hFFF0 : (k == 3) ? 16'd200 : (k == 4) ? 16'd300 : 16'd400);
        end

        for (int i = 0; i < NV; i++) begin
            wr(4'd1, VEC[i][79:64]);
            wr(4'd2, VEC[i][63:48]);
            wr(4'd0, VEC[i][47:32]);
            ticks(int'(VEC[i][31:16]));
            rd(4'd0, v);
            chk($sformatf("R2/R3/R4/R5/R6/R7 vector %0d", i), v, VEC[i][15:0]);
        end
        rd(4'd2, v);
        chk("R12 control readback", v, 16'h0F);
        wr(4'd1, 16'h1234);
        rd(4'd1, v);
        chk("R12 divider readback", v, 16'h1234);
        rd(4'd12, v);
        chk("R12 unmapped reads zero", v, 16'h0);

        // R8: counter write restarts the prescaler
        wr(4'd1, 16'd3); wr(4'd2, 16'h0F);
        wr(4'd0, 16'd9);
        ticks(2);
        wr(4'd0, 16'd10);
        ticks(3);
        rd(4'd0, v);
        chk("R8 prescaler restarted", v, 16'd10);
        ticks(1);
        rd(4'd0, v);
        chk("R8 step after full period", v, 16'd11);

        // R3: freeze holds prescaler position
        wr(4'd1, 16'd1);
        wr(4'd0, 16'd0);
        ticks(1);
        wr(4'd2, 16'h1F);
        ticks(5);
        rd(4'd0, v);
        chk("R3 frozen count", v, 16'd0);
        wr(4'd2, 16'h0F);
        ticks(1);
        rd(4'd0, v);
        chk("R3 prescaler kept position", v, 16'd1);

        // R9/R10/R11 status and irq
        wr(4'd1, 16'd0);
        wr(4'd0, 16'd4);
        wr(4'd9, 16'h3F);
        idle(1);
        rd(4'd9, v);
        chk("R10 status cleared", v, 16'h0);
        ticks(1);
        idle(1);
        rd(4'd9, v);
        chk("R9 cmp1 sets bit0", v, 16'h01);
        chk("R11 irq masked off", 16'(irq), 16'h0);
        wr(4'd10, 16'h02);
        chk("R11 other mask bit", 16'(irq), 16'h0);
        wr(4'd10, 16'h01);
        chk("R11 irq asserted", 16'(irq), 16'h1);
        wr(4'd9, 16'h01);
        rd(4'd9, v);
        chk("R10 match wins over clear", v, 16'h01);
        ticks(1);
        wr(4'd9, 16'h01);
        rd(4'd9, v);
        chk("R10 cleared after match ends", v, 16'h0);
        chk("R11 irq dropped", 16'(irq), 16'h0);
        wr(4'd0, 16'd200);
        idle(1);
        wr(4'd0, 16'd7);
        rd(4'd9, v);
        chk("R9 cmp4 sets bit3", v, 16'h08);
        wr(4'd9, 16'h37);
        rd(4'd9, v);
        chk("R10 zero bit keeps status", v, 16'h08);
        wr(4'd9, 16'h08);
        rd(4'd9, v);
        chk("R10 one bit clears status", v, 16'h0);

        finish_run();
    end
endmodule